// File: doc/BRIEF.md
# Burst-Capable Synchronous Serial Master

This block is a full-duplex serial master for SPI and Microwire style slaves. Software sets up the transfer through a small register bus. It writes up to four 32-bit data words and a clock divider. It then writes a control word that gives the word length (1 to 32 bits), the number of words (1 to 4), the bit order, the slave to select, and the serial clock edge used to launch transmit bits and the edge used to sample receive bits. The two edges are chosen independently. A single command then shifts every word back to back while the chosen slave-select line stays low.

Received bits replace the transmitted ones in the same data registers. Each received word ends up right-aligned in the register that held its transmit word. The go bit reads back as busy until the last serial clock period has ended. At that point a sticky done flag is raised and drives the interrupt output. The whole design runs on a single clock, and the serial clock is produced by counting system clock cycles.

Top module: `spi_burst_master`

## Requirements
- R1: The serial clock idles low. During a transfer it has a period of 2×(div+1) system clock cycles, where div is register 1 (16 bits), and it starts and ends low. It runs exactly words×length periods and the first rising edge comes div+1 cycles after the go write.
- R2: Both select outputs are high when idle. During a transfer only the line chosen by control bit 11 is low: bit 11 = 0 drives ss_n[0] low and bit 11 = 1 drives ss_n[1] low. That line stays low from the go write until the last falling edge.
- R3: Bit order is set by control bit 8 (0 = MSB first, 1 = LSB first). Transmit bit k is shown on mosi from the k-th transmit edge onward, or from the start when k = 0. The transmit edge is set by control bit 9 (0 = rising, 1 = falling). With rising edges, the first rising edge does not advance the bit.
- R4: The receive edge is set by control bit 10 (0 = rising, 1 = falling). Each receive edge samples miso into the next bit position of the current word, using the same bit order. Word n (in transfer order) goes into data register n (address 4+n). Only bits below the word length are written; higher bits keep their value.
- R5: Control bits 5:1 hold the word length minus one, and bits 7:6 hold the word count minus one. Words follow each other with no gap in the serial clock.
- R6: Control bit 0 is the go bit. Writing 1 starts a transfer, and the bit reads back 1 until the last falling edge, then 0. Control bit 13 is the done flag and equals irq. It is set when a transfer ends, and it is cleared by writing control with bit 13 = 1 or by starting a transfer.
- R7: While a transfer runs, all register writes are ignored. This covers data, divider and control.
- R8: After reset all registers read zero, irq is low, sclk is low and both select lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 control, 1 divider, 4–7 data words |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Done interrupt, equals the done flag |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 2 | Active-low slave selects |
| miso | input | 1 | Serial data in |

## Verification
The in-RTL assertions check on every cycle that at most one select line is low and that the serial clock is low when idle. They also check that the serial clock only moves on a divider terminal count, that the done flag is up when busy falls, that the configuration stays frozen during a transfer, and that the bit counters stay inside the word. Other properties can only be shown by the bench, which compares against its cycle-by-cycle model across word lengths, word counts, edge pairings, bit orders and dividers: the exact position of each clock edge, which bit is on mosi after each edge, and which miso bit lands in which register bit. The same holds for writes ignored during a transfer and for bits above the word length being kept.

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter int DIVW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  output logic [1:0]  ss_n,
  input  logic        miso
);
  localparam int NWORD = 4;

  logic [31:0]     dat [NWORD];
  logic [DIVW-1:0] div_q, hcnt;
  logic [4:0]      wl, tb, rb;
  logic [1:0]      nw;
  logic [2:0]      tw, rw;
  logic [7:0]      fcnt;
  logic            lsb, txn, rxn, sel, busy, done, sclk_q, mosi_q, first_rise;

  wire [7:0] nbits = 8'(({6'd0, nw} + 8'd1) * ({3'd0, wl} + 8'd1));
  wire       ev    = busy && (hcnt == div_q);
  wire       rise  = ev && !sclk_q;
  wire       fall  = ev && sclk_q;
  wire       tx_go = txn ? fall : (rise && !first_rise);
  wire       rx_go = rxn ? fall : rise;

  wire [4:0] tb_n = (tb == wl) ? 5'd0 : tb + 5'd1;
  wire [2:0] tw_n = (tb == wl) ? tw + 3'd1 : tw;
  wire [4:0] tpos = lsb ? tb_n : wl - tb_n;
  wire [4:0] rpos = lsb ? rb : wl - rb;
  wire       tx_in = (tw_n <= {1'b0, nw});
  wire       wr_ok = reg_we && !busy;

  assign sclk = sclk_q;
  assign mosi = mosi_q;
  assign irq  = done;
  assign ss_n = !busy ? 2'b11 : (sel ? 2'b01 : 2'b10);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0: reg_rdata = {18'd0, done, 1'b0, sel, rxn, txn, lsb, nw, wl, busy};
      3'd1: reg_rdata = 32'(div_q);
      3'd4, 3'd5, 3'd6, 3'd7: reg_rdata = dat[reg_addr[1:0]];
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORD; i++) dat[i] <= '0;
      div_q <= '0; hcnt <= '0; wl <= '0; nw <= '0;
      tb <= '0; rb <= '0; tw <= '0; rw <= '0; fcnt <= '0;
      lsb <= 1'b0; txn <= 1'b0; rxn <= 1'b0; sel <= 1'b0;
      busy <= 1'b0; done <= 1'b0; sclk_q <= 1'b0; mosi_q <= 1'b0;
      first_rise <= 1'b0;
    end else if (wr_ok) begin
      case (reg_addr)
        3'd0: begin
          wl  <= reg_wdata[5:1];
          nw  <= reg_wdata[7:6];
          lsb <= reg_wdata[8];
          txn <= reg_wdata[9];
          rxn <= reg_wdata[10];
          sel <= reg_wdata[11];
          if (reg_wdata[13]) done <= 1'b0;
          if (reg_wdata[0]) begin
            busy <= 1'b1; done <= 1'b0;
            hcnt <= '0; sclk_q <= 1'b0; first_rise <= 1'b1;
            tb <= '0; rb <= '0; tw <= '0; rw <= '0; fcnt <= '0;
            mosi_q <= dat[0][reg_wdata[8] ? 5'd0 : reg_wdata[5:1]];
          end
        end
        3'd1: div_q <= reg_wdata[DIVW-1:0];
        3'd4, 3'd5, 3'd6, 3'd7: dat[reg_addr[1:0]] <= reg_wdata;
        default: ;
      endcase
    end else if (busy) begin
      if (ev) begin
        hcnt   <= '0;
        sclk_q <= !sclk_q;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
      if (rise) first_rise <= 1'b0;
      if (fall) begin
        if (fcnt == nbits - 8'd1) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          fcnt <= fcnt + 8'd1;
        end
      end
      if (tx_go) begin
        tb     <= tb_n;
        tw     <= tw_n;
        mosi_q <= tx_in ? dat[tw_n[1:0]][tpos] : 1'b0;
      end
      if (rx_go) begin
        dat[rw[1:0]][rpos] <= miso;
        if (rb == wl) begin
          rb <= '0;
          rw <= rw + 3'd1;
        end else begin
          rb <= rb + 5'd1;
        end
      end
    end
  end

  // R2
  ss_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ss_n));

  // R1
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk_q);

  // R1
  sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hcnt != div_q) |=> $stable(sclk_q));

  // R6
  done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(div_q) && $stable(wl) && $stable(nw)));

  // R5
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tb <= wl && rb <= wl));
endmodule

// File: tb/spi_burst_master_bench.sv
module spi_burst_master_bench;
  logic        clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, miso = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, sclk, mosi;
  logic [1:0]  ss_n;

  spi_burst_master u_spi_burst_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sclk(sclk),
    .mosi(mosi), .ss_n(ss_n), .miso(miso));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0, s_cyc = 0;
  bit m_busy = 0;
  int m_len, m_nw, m_half, m_total;
  bit m_lsb, m_txn, m_rxn, m_sel;
  int cur_div = 0;
  logic [31:0] tx_mem [4];
  logic [127:0] slave;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic tx_bit(input int k);
    int w, b, p;
    if (k >= m_total) return 1'b0;
    w = k / m_len; b = k % m_len;
    p = m_lsb ? b : m_len - 1 - b;
    return tx_mem[w][p];
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (reg_we && reg_addr == 3'd0 && reg_wdata[0] && !m_busy) begin
      m_busy = 1;
      s_cyc  = cyc;
      m_len  = int'(reg_wdata[5:1]) + 1;
      m_nw   = int'(reg_wdata[7:6]) + 1;
      m_lsb  = reg_wdata[8];
      m_txn  = reg_wdata[9];
      m_rxn  = reg_wdata[10];
      m_sel  = reg_wdata[11];
      m_half = cur_div + 1;
      m_total = m_len * m_nw;
    end
  end

  always @(negedge clk) begin
    if (m_busy) begin
      int m, t, r, f, k, j;
      m = cyc - s_cyc;
      if (m >= 2 * m_total * m_half) begin
        m_busy = 0;
        chk("R1 sclk low at end", {31'd0, sclk}, 32'd0);
        chk("R2 selects released", {30'd0, ss_n}, 32'd3);
        chk("R6 irq at end", {31'd0, irq}, 32'd1);
      end else begin
        t = m / m_half;
        r = (t + 1) / 2;
        f = t / 2;
        chk("R1 sclk level", {31'd0, sclk}, {31'd0, t[0]});
        chk("R2 select", {30'd0, ss_n}, m_sel ? 32'd1 : 32'd2);
        k = m_txn ? f : ((r > 0) ? r - 1 : 0);
        chk("R3 mosi bit", {31'd0, mosi}, {31'd0, tx_bit(k)});
        j = m_rxn ? f : r;
        miso = (j < m_total) ? slave[j] : 1'b0;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run(input int len, input int nw, input bit lsb, input bit txn,
                     input bit rxn, input bit sel, input int div, input bit poke);
    logic [31:0] v, ctrl;
    logic [31:0] expw [4];
    wr(3'd1, 32'(div));
    cur_div = div;
    for (int i = 0; i < 4; i++) begin
      tx_mem[i] = $urandom;
      wr(3'(4 + i), tx_mem[i]);
    end
    slave = {$urandom, $urandom, $urandom, $urandom};
    ctrl = 32'd1 | (32'(len - 1) << 1) | (32'(nw - 1) << 6) | (32'(lsb) << 8)
         | (32'(txn) << 9) | (32'(rxn) << 10) | (32'(sel) << 11);
    wr(3'd0, ctrl);
    rd(3'd0, v);
    chk("R6 go reads busy", {31'd0, v[0]}, 32'd1);
    chk("R5 length and count fields", {24'd0, v[7:1]}, {24'd0, ctrl[7:1]});
    if (poke) begin
      wr(3'd4, 32'hDEAD_BEEF);
      wr(3'd1, 32'd9);
      wr(3'd0, 32'h0000_2000);
    end
    while (m_busy) @(negedge clk);
    rd(3'd0, v);
    chk("R6 go cleared", {31'd0, v[0]}, 32'd0);
    chk("R6 done flag", {31'd0, v[13]}, 32'd1);
    if (poke) begin
      rd(3'd1, v);
      chk("R7 divider write ignored", v, 32'(div));
    end
    for (int w = 0; w < 4; w++) begin
      expw[w] = tx_mem[w];
      if (w < nw)
        for (int b = 0; b < len; b++)
          expw[w][lsb ? b : len - 1 - b] = slave[w * len + b];
      rd(3'(4 + w), v);
      chk("R4 received word", v, expw[w]);
    end
    wr(3'd0, 32'h0000_2000);
    chk("R6 done cleared", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd0, v);
    chk("R8 control reset", v, 32'd0);
    rd(3'd5, v);
    chk("R8 data reset", v, 32'd0);
    chk("R8 idle pins", {29'd0, irq, ss_n}, 32'd3);
    chk("R8 sclk reset", {31'd0, sclk}, 32'd0);
    run(8, 1, 0, 1, 0, 0, 0, 0);
    run(32, 4, 1, 0, 1, 1, 2, 1);
    run(5, 3, 0, 0, 0, 0, 1, 0);
    run(17, 2, 1, 1, 1, 1, 3, 0);
    run(1, 4, 0, 1, 0, 1, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule